// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns one virtual address into a physical address by reading a first-level descriptor from memory and, when that descriptor points at a second-level table, a second descriptor. Memory is reached through a simple read port. The port holds a request with its address until a response arrives, and the response may come in the same cycle. With each request the caller supplies the access kind, a user/privileged flag, the translation table base, the 32-bit domain control word, the two protection-select bits of the system control register and a process ID used for low-address remapping. All of these are captured when the request is accepted.

The walker handles sections at the first level. At the second level it handles coarse and fine tables holding 64 KB, 4 KB and 1 KB pages. It checks the domain and the access-permission field and returns one of two results. A successful walk gives the physical address and read/write permission flags. A failed walk gives an 8-bit status: the fault code in bits 3:0 and the domain number in bits 7:4. Only one walk is in flight at a time, and a one-cycle done strobe marks its end. Nothing is cached.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is low and in the cycle after it, `walk_done`, `walk_fault`, `mem_rd_valid`, `perm_read`, `perm_write`, `fault_status` and `phys_addr` are all zero. A reset asserted in the middle of a walk drops `mem_rd_valid` and produces no done strobe.
- R2: A virtual address below 0x0200_0000 has `ctx_pid` added to it before translation. An address at or above 0x0200_0000 is used unchanged.
- R3: The first read goes to `ttb_base[31:14]`, then modified-address bits 31:20, then two zero bits.
- R4: A first-level descriptor whose bits 1:0 are 00 ends the walk after one read with fault code 5.
- R5: The domain number is descriptor bits 8:5, and its access value is `dom_ctl` bits [2*dom+1 : 2*dom]. Values 00 (no access) and 10 end the walk after one read with code 9 for a section (type 10) or code 11 for a table (type 01 coarse, type 11 fine).
- R6: A section gives the physical address from descriptor bits 31:20 followed by address bits 19:0. Its AP field is descriptor bits 11:10.
- R7: The second read goes to descriptor bits 31:10 followed by address bits 19:12 for a coarse table, and to descriptor bits 31:12 followed by address bits 19:10 for a fine table. Both addresses end in two zero bits.
- R8: Second-level type 01 (64 KB) gives descriptor bits 31:16 followed by address bits 15:0. Type 10 (4 KB) gives descriptor bits 31:12 followed by address bits 11:0. For both, AP is the 2-bit field at descriptor bit 4 + 2*address[11:10].
- R9: Second-level type 11 in a fine table is a 1 KB page: descriptor bits 31:10 followed by address bits 9:0, with AP in bits 5:4. Type 00 in any table, or type 11 in a coarse table, gives fault code 7.
- R10: `req_kind` 01 is a data write; 00 is a data read; 10 and 11 are instruction fetches, which count as reads. `prot_sel[1]` is the ROM-protect bit and `prot_sel[0]` the system-protect bit. The AP decode for a client domain is as follows. AP 11 gives read/write. AP 01 gives read/write when privileged and nothing for user. AP 10 gives read/write when privileged; for user it gives read only, and a user write is denied. AP 00 denies any write; a read then gets read-only when `prot_sel`=10, read-only for privileged only when `prot_sel`=01, and nothing otherwise.
- R11: A domain access value of 11 (manager) grants read/write whatever the AP field and `prot_sel`.
- R12: A denied access gives code 13 for a section and 15 for a page. On any fault, `fault_status` = code | (domain << 4), and `phys_addr`, `perm_read` and `perm_write` are zero. On success `fault_status` is zero.
- R13: `walk_done` is high for exactly one cycle, in the cycle after the last read response. While a read waits for its response, `mem_rd_valid` stays high and `mem_rd_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a walk (sampled only when idle) |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 1x fetch |
| req_user | input | 1 | 1 = user access, 0 = privileged |
| ttb_base | input | 32 | Translation table base |
| dom_ctl | input | 32 | Sixteen 2-bit domain access values |
| prot_sel | input | 2 | [1] ROM-protect, [0] system-protect |
| ctx_pid | input | 32 | Process ID added to low addresses |
| mem_rd_valid | output | 1 | Read request to memory |
| mem_rd_addr | output | 32 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (descriptor) |
| walk_done | output | 1 | One-cycle end-of-walk strobe |
| walk_fault | output | 1 | Walk ended in a fault |
| fault_status | output | 8 | Domain in 7:4, fault code in 3:0 |
| phys_addr | output | 32 | Translated address |
| perm_read | output | 1 | Read allowed |
| perm_write | output | 1 | Write allowed |

## Verification
A wrongly captured descriptor or a stale domain value shows up at the very next done strobe. It appears either as a wrong `fault_status` nibble or as a `phys_addr` whose high bits differ from the descriptor just served. A walker that takes the wrong state branch is visible one cycle earlier, on the read port: it issues a second read where none belongs, or omits one, or drives a second address that does not match the table-index rule. Each walk is judged by the addresses it reads, the number of reads, and the result bits in the done cycle. A stray extra done pulse is caught one cycle later.

// File: rtl/pgwalk_pkg.sv
// Shared constants for the page table walker: walk states, access kinds,
// descriptor type codes and fault codes.
package pgwalk_pkg;
    localparam int unsigned AW   = 32;
    localparam int unsigned FS_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2
    } walk_state_t;

    localparam logic [1:0] ACC_STORE = 2'b01;

    localparam logic [1:0] L1_FAULT   = 2'b00;
    localparam logic [1:0] L1_COARSE  = 2'b01;
    localparam logic [1:0] L1_SECTION = 2'b10;
    localparam logic [1:0] L1_FINE    = 2'b11;

    localparam logic [3:0] FC_SEC_XLATE  = 4'd5;
    localparam logic [3:0] FC_PAGE_XLATE = 4'd7;
    localparam logic [3:0] FC_SEC_DOM    = 4'd9;
    localparam logic [3:0] FC_PAGE_DOM   = 4'd11;
    localparam logic [3:0] FC_SEC_PERM   = 4'd13;
    localparam logic [3:0] FC_PAGE_PERM  = 4'd15;
endpackage

// File: rtl/pgwalk_remap.sv
// Low-address remap: adds the process ID to addresses under LIMIT.
// Assumes the sum wraps modulo 2^AW. Purely combinational.
module pgwalk_remap #(
    parameter int unsigned    AW    = 32,
    parameter logic [AW-1:0]  LIMIT = 'h0200_0000
) (
    input  logic [AW-1:0] vaddr,
    input  logic [AW-1:0] pid,
    output logic [AW-1:0] mvaddr
);
    // Select the remapped or the original address.
    assign mvaddr = (vaddr < LIMIT) ? vaddr + pid : vaddr;
endmodule

// File: rtl/pgwalk_l2dec.sv
// Second-level descriptor decode: page type, physical address and the
// AP field. Assumes 32-bit descriptors; tiny pages are legal only when
// the table is fine. Purely combinational.
module pgwalk_l2dec (
    input  logic [31:0] desc,
    input  logic [31:0] va,
    input  logic        fine,
    output logic        valid,
    output logic [31:0] pa,
    output logic [1:0]  ap
);
    logic [1:0] sub_ap;

    // Pick the subpage AP pair chosen by va[11:10].
    always_comb begin
        unique case (va[11:10])
            2'd0: sub_ap = desc[5:4];
            2'd1: sub_ap = desc[7:6];
            2'd2: sub_ap = desc[9:8];
            default: sub_ap = desc[11:10];
        endcase
    end

    // Decode the page type into address and permission field.
    always_comb begin
        valid = 1'b1;
        pa    = '0;
        ap    = sub_ap;
        unique case (desc[1:0])
            2'b01: pa = {desc[31:16], va[15:0]};
            2'b10: pa = {desc[31:12], va[11:0]};
            2'b11: begin
                valid = fine;
                pa    = {desc[31:10], va[9:0]};
                ap    = desc[5:4];
            end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/pgwalk_perm.sv
// Access permission decode from AP, domain access value, access kind,
// privilege and the two protection-select bits. Write permission is
// only ever granted together with read permission. Combinational.
module pgwalk_perm
    import pgwalk_pkg::*;
(
    input  logic [1:0] ap,
    input  logic [1:0] dom_acc,
    input  logic [1:0] kind,
    input  logic       user,
    input  logic [1:0] prot_sel,
    output logic       can_rd,
    output logic       can_wr
);
    logic is_wr;
    assign is_wr = (kind == ACC_STORE);

    // Evaluate the permission table.
    always_comb begin
        can_rd = 1'b0;
        can_wr = 1'b0;
        if (dom_acc == 2'b11) begin
            can_rd = 1'b1;
            can_wr = 1'b1;
        end else begin
            unique case (ap)
                2'b00: begin
                    if (!is_wr) begin
                        if (prot_sel == 2'b10)      can_rd = 1'b1;
                        else if (prot_sel == 2'b01) can_rd = !user;
                    end
                end
                2'b01: begin
                    can_rd = !user;
                    can_wr = !user;
                end
                2'b10: begin
                    can_rd = !(user && is_wr);
                    can_wr = !user;
                end
                default: begin
                    can_rd = 1'b1;
                    can_wr = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/pgwalk_top.sv
// Two-level page table walker. Captures a request, reads the first-level
// descriptor, optionally a second-level one, and reports an address with
// permissions or a fault status. Assumes one walk at a time and a memory
// port that may answer in the same cycle as the request.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter logic [31:0] REMAP_LIMIT = 32'h0200_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_vaddr,
    input  logic [1:0]      req_kind,
    input  logic            req_user,
    input  logic [AW-1:0]   ttb_base,
    input  logic [31:0]     dom_ctl,
    input  logic [1:0]      prot_sel,
    input  logic [AW-1:0]   ctx_pid,
    output logic            mem_rd_valid,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic            mem_rsp_valid,
    input  logic [31:0]     mem_rsp_data,
    output logic            walk_done,
    output logic            walk_fault,
    output logic [FS_W-1:0] fault_status,
    output logic [AW-1:0]   phys_addr,
    output logic            perm_read,
    output logic            perm_write
);
    walk_state_t state_q;
    logic [AW-1:0] va_q, l2a_q, mva;
    logic [17:0]   ttb_q;
    logic [31:0]   dctl_q;
    logic [1:0]    kind_q, prot_q, dacc_q;
    logic          user_q, fine_q;
    logic [3:0]    dom_q;

    logic [1:0]  l1_type, l1_dacc, ap_sel, dacc_sel, l2_ap;
    logic [3:0]  l1_dom;
    logic [31:0] dacc_shift, sec_pa, l2_idx, l2_pa;
    logic        l2_ok, can_rd, can_wr;

    logic        fin, fin_fault, go_l2;
    logic [3:0]  fin_code, fin_dom;
    logic [31:0] fin_pa;

    pgwalk_remap #(.AW(AW), .LIMIT(REMAP_LIMIT)) remap_i (
        .vaddr(req_vaddr), .pid(ctx_pid), .mvaddr(mva)
    );

    pgwalk_l2dec l2dec_i (
        .desc(mem_rsp_data), .va(va_q), .fine(fine_q),
        .valid(l2_ok), .pa(l2_pa), .ap(l2_ap)
    );

    pgwalk_perm perm_i (
        .ap(ap_sel), .dom_acc(dacc_sel), .kind(kind_q), .user(user_q),
        .prot_sel(prot_q), .can_rd(can_rd), .can_wr(can_wr)
    );

    // First-level field extraction and second-level table index.
    always_comb begin
        l1_type    = mem_rsp_data[1:0];
        l1_dom     = mem_rsp_data[8:5];
        dacc_shift = dctl_q >> {l1_dom, 1'b0};
        l1_dacc    = dacc_shift[1:0];
        sec_pa     = {mem_rsp_data[31:20], va_q[19:0]};
        l2_idx     = (l1_type == L1_COARSE)
                   ? {mem_rsp_data[31:10], va_q[19:12], 2'b00}
                   : {mem_rsp_data[31:12], va_q[19:10], 2'b00};
        ap_sel     = (state_q == ST_L2) ? l2_ap  : mem_rsp_data[11:10];
        dacc_sel   = (state_q == ST_L2) ? dacc_q : l1_dacc;
    end

    // Read port drive.
    assign mem_rd_valid = (state_q != ST_IDLE);
    assign mem_rd_addr  = (state_q == ST_L2) ? l2a_q
                                             : {ttb_q, va_q[31:20], 2'b00};

    // Decide the outcome of the read that returns this cycle.
    always_comb begin
        fin = 1'b0; fin_fault = 1'b0; go_l2 = 1'b0;
        fin_code = '0; fin_dom = '0; fin_pa = '0;
        if (mem_rsp_valid && state_q == ST_L1) begin
            fin_dom = l1_dom;
            if (l1_type == L1_FAULT) begin
                fin = 1'b1; fin_fault = 1'b1; fin_code = FC_SEC_XLATE;
            end else if (!l1_dacc[0]) begin
                fin = 1'b1; fin_fault = 1'b1;
                fin_code = (l1_type == L1_SECTION) ? FC_SEC_DOM : FC_PAGE_DOM;
            end else if (l1_type == L1_SECTION) begin
                fin = 1'b1;
                if (!(can_rd || can_wr)) begin
                    fin_fault = 1'b1; fin_code = FC_SEC_PERM;
                end else begin
                    fin_pa = sec_pa;
                end
            end else begin
                go_l2 = 1'b1;
            end
        end else if (mem_rsp_valid && state_q == ST_L2) begin
            fin = 1'b1;
            fin_dom = dom_q;
            if (!l2_ok) begin
                fin_fault = 1'b1; fin_code = FC_PAGE_XLATE;
            end else if (!(can_rd || can_wr)) begin
                fin_fault = 1'b1; fin_code = FC_PAGE_PERM;
            end else begin
                fin_pa = l2_pa;
            end
        end
    end

    // Walk state, captured request and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            va_q         <= '0;
            ttb_q        <= '0;
            dctl_q       <= '0;
            kind_q       <= '0;
            prot_q       <= '0;
            user_q       <= 1'b0;
            l2a_q        <= '0;
            fine_q       <= 1'b0;
            dom_q        <= '0;
            dacc_q       <= '0;
            walk_done    <= 1'b0;
            walk_fault   <= 1'b0;
            fault_status <= '0;
            phys_addr    <= '0;
            perm_read    <= 1'b0;
            perm_write   <= 1'b0;
        end else begin
            walk_done <= 1'b0;
            if (state_q == ST_IDLE && req_valid) begin
                va_q    <= mva;
                ttb_q   <= ttb_base[31:14];
                dctl_q  <= dom_ctl;
                kind_q  <= req_kind;
                prot_q  <= prot_sel;
                user_q  <= req_user;
                state_q <= ST_L1;
            end
            if (go_l2) begin
                l2a_q   <= l2_idx;
                fine_q  <= (l1_type == L1_FINE);
                dom_q   <= l1_dom;
                dacc_q  <= l1_dacc;
                state_q <= ST_L2;
            end
            if (fin) begin
                walk_done    <= 1'b1;
                walk_fault   <= fin_fault;
                fault_status <= fin_fault ? {fin_dom, fin_code} : '0;
                phys_addr    <= fin_pa;
                perm_read    <= !fin_fault && can_rd;
                perm_write   <= !fin_fault && can_wr;
                state_q      <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/pgwalk_checker.sv
// Port-level protocol and result checks for the page table walker,
// attached with bind. Observes only the top-level ports.
module pgwalk_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_rd_valid,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rsp_valid,
    input logic        walk_done,
    input logic        walk_fault,
    input logic [7:0]  fault_status,
    input logic [31:0] phys_addr,
    input logic        perm_read,
    input logic        perm_write
);
    // R13: done is a single-cycle strobe
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);

    // R13: a pending read keeps its request and address
    assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rsp_valid) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R13: done follows an accepted read
    assert_done_after_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> $past(mem_rd_valid && mem_rsp_valid));

    // R12: fault codes are from the legal set
    assert_code_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && walk_fault) |-> (fault_status[3:0] inside {4'd5, 4'd7, 4'd9, 4'd11, 4'd13, 4'd15}));

    // R12: a fault carries no address and no permission
    assert_fault_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && walk_fault) |-> (!perm_read && !perm_write && phys_addr == 32'd0));

    // R10: success grants at least read, and no fault status
    assert_ok_perm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && !walk_fault) |-> (perm_read && fault_status == 8'd0));

    // R10: write permission never appears without read permission
    assert_wr_needs_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        perm_write |-> perm_read);
endmodule

bind pgwalk_top pgwalk_checker chk_i (
    .clk(clk), .rst_n(rst_n), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .walk_done(walk_done), .walk_fault(walk_fault),
    .fault_status(fault_status), .phys_addr(phys_addr),
    .perm_read(perm_read), .perm_write(perm_write)
);

// File: tb/pgwalk_top_tb_top.sv
// Vector-driven bench for the page table walker with a latency-controlled
// memory model, then directed reset and read-hold tests.
module pgwalk_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TTB   = 32'h1234_C000;
    localparam logic [31:0] LIMIT = 32'h0200_0000;
    localparam logic [31:0] D     = 32'h5555_5555;
    localparam logic [31:0] VA    = 32'h3040_5678;
    localparam logic [31:0] VB    = 32'h3045_6ABC;

    typedef struct packed {
        logic [31:0] vaddr;
        logic [31:0] pid;
        logic [1:0]  kind;
        logic        user;
        logic [31:0] dacr;
        logic [1:0]  prot;
        logic [31:0] l1;
        logic [31:0] l2;
        logic [1:0]  lat;
        logic        e_fault;
        logic [7:0]  e_stat;
        logic [31:0] e_pa;
        logic        e_rd;
        logic        e_wr;
        logic [1:0]  e_reads;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        // R6 section, AP 11 full access
        '{VA, 0, 2'd0, 1'b0, D, 2'b00, 32'h7AB0_0C02, 0, 2'd0, 1'b0, 8'h00, 32'h7AB0_5678, 1'b1, 1'b1, 2'd1},
        // R10 R12 AP 01 user read denied, domain 3
        '{VA, 0, 2'd0, 1'b1, D, 2'b00, 32'h7AB0_0462, 0, 2'd0, 1'b1, 8'h3D, 32'h0, 1'b0, 1'b0, 2'd1},
        // R10 AP 01 privileged write allowed, latency 1
        '{VA, 0, 2'd1, 1'b0, D, 2'b00, 32'h7AB0_0462, 0, 2'd1, 1'b0, 8'h00, 32'h7AB0_5678, 1'b1, 1'b1, 2'd1},
        // R10 AP 10 user write denied
        '{VA, 0, 2'd1, 1'b1, D, 2'b00, 32'h7AB0_0862, 0, 2'd0, 1'b1, 8'h3D, 32'h0, 1'b0, 1'b0, 2'd1},
        // R10 AP 10 user read is read-only
        '{VA, 0, 2'd0, 1'b1, D, 2'b00, 32'h7AB0_0862, 0, 2'd0, 1'b0, 8'h00, 32'h7AB0_5678, 1'b1, 1'b0, 2'd1},
        // R10 AP 00 system-protect, privileged read
        '{VA, 0, 2'd0, 1'b0, D, 2'b01, 32'h7AB0_0002, 0, 2'd0, 1'b0, 8'h00, 32'h7AB0_5678, 1'b1, 1'b0, 2'd1},
        // R10 AP 00 system-protect, user read denied
        '{VA, 0, 2'd0, 1'b1, D, 2'b01, 32'h7AB0_0002, 0, 2'd0, 1'b1, 8'h0D, 32'h0, 1'b0, 1'b0, 2'd1},
        // R10 AP 00 ROM-protect, user read allowed
        '{VA, 0, 2'd0, 1'b1, D, 2'b10, 32'h7AB0_0002, 0, 2'd0, 1'b0, 8'h00, 32'h7AB0_5678, 1'b1, 1'b0, 2'd1},
        // R10 AP 00 ROM-protect, write denied
        '{VA, 0, 2'd1, 1'b0, D, 2'b10, 32'h7AB0_0002, 0, 2'd0, 1'b1, 8'h0D, 32'h0, 1'b0, 1'b0, 2'd1},
        // R11 manager domain overrides AP 00
        '{VA, 0, 2'd1, 1'b1, 32'h5555_5557, 2'b00, 32'h7AB0_0002, 0, 2'd0, 1'b0, 8'h00, 32'h7AB0_5678, 1'b1, 1'b1, 2'd1},
        // R5 section domain 5 no access
        '{VA, 0, 2'd0, 1'b0, 32'h5555_5155, 2'b00, 32'h7AB0_0CA2, 0, 2'd0, 1'b1, 8'h59, 32'h0, 1'b0, 1'b0, 2'd1},
        // R5 coarse table domain 5 value 10
        '{VA, 0, 2'd0, 1'b0, 32'h5555_5955, 2'b00, 32'h00AB_C4A1, 0, 2'd0, 1'b1, 8'h5B, 32'h0, 1'b0, 1'b0, 2'd1},
        // R4 first-level fault descriptor, domain 3
        '{VA, 0, 2'd0, 1'b0, D, 2'b00, 32'h0000_0060, 0, 2'd0, 1'b1, 8'h35, 32'h0, 1'b0, 1'b0, 2'd1},
        // R7 R8 coarse, 4 KB page, subpage 2 AP 11
        '{VB, 0, 2'd1, 1'b1, D, 2'b00, 32'h00AB_C401, 32'hCAFE_1302, 2'd0, 1'b0, 8'h00, 32'hCAFE_1ABC, 1'b1, 1'b1, 2'd2},
        // R8 R12 subpage 2 AP 01 user denied, latency 2
        '{VB, 0, 2'd0, 1'b1, D, 2'b00, 32'h00AB_C401, 32'hCAFE_1DF2, 2'd2, 1'b1, 8'h0F, 32'h0, 1'b0, 1'b0, 2'd2},
        // R8 coarse, 64 KB page
        '{VB, 0, 2'd1, 1'b1, D, 2'b00, 32'h00AB_C401, 32'hBEEF_0301, 2'd0, 1'b0, 8'h00, 32'hBEEF_6ABC, 1'b1, 1'b1, 2'd2},
        // R7 R9 fine table, 1 KB page
        '{VB, 0, 2'd1, 1'b1, D, 2'b00, 32'h00AB_D003, 32'hF00D_1433, 2'd1, 1'b0, 8'h00, 32'hF00D_16BC, 1'b1, 1'b1, 2'd2},
        // R9 1 KB type in coarse table faults
        '{VB, 0, 2'd0, 1'b0, D, 2'b00, 32'h00AB_C401, 32'hF00D_1433, 2'd0, 1'b1, 8'h07, 32'h0, 1'b0, 1'b0, 2'd2},
        // R9 second-level type 00, domain 2
        '{VB, 0, 2'd0, 1'b0, D, 2'b00, 32'h00AB_D043, 32'h0, 2'd0, 1'b1, 8'h27, 32'h0, 1'b0, 1'b0, 2'd2},
        // R10 instruction fetch by user under AP 10
        '{VA, 0, 2'd2, 1'b1, D, 2'b00, 32'h7AB0_0862, 0, 2'd0, 1'b0, 8'h00, 32'h7AB0_5678, 1'b1, 1'b0, 2'd1},
        // R2 low address remapped by process ID
        '{32'h0012_3456, 32'h0500_0000, 2'd0, 1'b0, D, 2'b00, 32'h7AB0_0C02, 0, 2'd0, 1'b0, 8'h00, 32'h7AB2_3456, 1'b1, 1'b1, 2'd1},
        // R2 boundary address not remapped
        '{32'h0200_0000, 32'h0500_0000, 2'd0, 1'b0, D, 2'b00, 32'h7AB0_0C02, 0, 2'd0, 1'b0, 8'h00, 32'h7AB0_0000, 1'b1, 1'b1, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [31:0] ttb_base = TTB;
    logic [31:0] dom_ctl = '0;
    logic [1:0]  prot_sel = '0;
    logic [31:0] ctx_pid = '0;
    logic        mem_rd_valid, mem_rsp_valid;
    logic [31:0] mem_rd_addr, mem_rsp_data;
    logic        walk_done, walk_fault, perm_read, perm_write;
    logic [7:0]  fault_status;
    logic [31:0] phys_addr;

    int n_checks = 0;
    int n_errs = 0;

    logic [31:0] rcnt = '0;
    logic [31:0] base = '0;
    logic [31:0] rlog [8];
    int          wctr = 0;
    int          cur_lat = 0;
    logic [31:0] cur_l1 = '0;
    logic [31:0] cur_l2 = '0;

    pgwalk_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .ttb_base(ttb_base),
        .dom_ctl(dom_ctl), .prot_sel(prot_sel), .ctx_pid(ctx_pid),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .walk_done(walk_done), .walk_fault(walk_fault),
        .fault_status(fault_status), .phys_addr(phys_addr),
        .perm_read(perm_read), .perm_write(perm_write)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: first read of a walk returns the first-level descriptor.
    always_comb begin
        mem_rsp_valid = mem_rd_valid && (wctr >= cur_lat);
        mem_rsp_data  = (rcnt == base) ? cur_l1 : cur_l2;
    end

    always @(posedge clk) begin
        if (mem_rd_valid && mem_rsp_valid) begin
            rlog[rcnt[2:0]] <= mem_rd_addr;
            rcnt <= rcnt + 1;
            wctr <= 0;
        end else if (mem_rd_valid) begin
            wctr <= wctr + 1;
        end else begin
            wctr <= 0;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mod_va(input vec_t v);
        return (v.vaddr < LIMIT) ? v.vaddr + v.pid : v.vaddr;
    endfunction

    function automatic logic [31:0] exp_l1(input vec_t v);
        logic [31:0] m = mod_va(v);
        return {TTB[31:14], m[31:20], 2'b00};
    endfunction

    function automatic logic [31:0] exp_l2(input vec_t v);
        logic [31:0] m = mod_va(v);
        if (v.l1[1:0] == 2'b01) return {v.l1[31:10], m[19:12], 2'b00};
        return {v.l1[31:12], m[19:10], 2'b00};
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        int n = 0;
        @(negedge clk);
        cur_l1 = v.l1; cur_l2 = v.l2; cur_lat = int'(v.lat); base = rcnt;
        req_vaddr = v.vaddr; ctx_pid = v.pid; req_kind = v.kind;
        req_user = v.user; dom_ctl = v.dacr; prot_sel = v.prot;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!walk_done && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk("R13", $sformatf("vec%0d done seen", idx), {31'd0, walk_done}, 32'd1);
        chk("R12", $sformatf("vec%0d fault", idx), {31'd0, walk_fault}, {31'd0, v.e_fault});
        chk("R12", $sformatf("vec%0d status", idx), {24'd0, fault_status}, {24'd0, v.e_stat});
        chk("R6", $sformatf("vec%0d phys", idx), phys_addr, v.e_pa);
        chk("R10", $sformatf("vec%0d rd", idx), {31'd0, perm_read}, {31'd0, v.e_rd});
        chk("R10", $sformatf("vec%0d wr", idx), {31'd0, perm_write}, {31'd0, v.e_wr});
        chk("R13", $sformatf("vec%0d reads", idx), rcnt - base, {30'd0, v.e_reads});
        chk("R3", $sformatf("vec%0d l1 addr", idx), rlog[base[2:0]], exp_l1(v));
        if (v.e_reads == 2'd2)
            chk("R7", $sformatf("vec%0d l2 addr", idx), rlog[base[2:0] + 3'd1], exp_l2(v));
        @(negedge clk);
        chk("R13", $sformatf("vec%0d done width", idx), {31'd0, walk_done}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", {31'd0, walk_done}, 32'd0);
        chk("R1", "rd_valid in reset", {31'd0, mem_rd_valid}, 32'd0);
        chk("R1", "status in reset", {24'd0, fault_status}, 32'd0);
        chk("R1", "phys in reset", phys_addr, 32'd0);
        chk("R1", "perm in reset", {30'd0, perm_read, perm_write}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "fault after reset", {31'd0, walk_fault}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R13 pending read held with stable address, then R1 reset mid-walk
        @(negedge clk);
        cur_lat = 10; cur_l1 = 32'h7AB0_0C02; base = rcnt;
        req_vaddr = VA; ctx_pid = 0; dom_ctl = D; req_kind = 0; req_user = 0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R13", "rd held while waiting", {31'd0, mem_rd_valid}, 32'd1);
        chk("R13", "rd addr stable", mem_rd_addr, {TTB[31:14], VA[31:20], 2'b00});
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "rd dropped by reset", {31'd0, mem_rd_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (12) begin
            @(negedge clk);
            chk("R1", "no done after reset", {31'd0, walk_done}, 32'd0);
        end

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end
endmodule